// File: doc/BRIEF.md
# Shadow Execution Consistency Checker

This block sits beside a processor that runs injected hardening sequences. When an instruction chosen for protection is fetched, a hardening sequence first announces its operation on a side channel. The processor then stores its source operands to a reserved checker address, executes the instruction itself, and stores its own result to the same address. The block collects these stores in a fixed order and recomputes the operation in a small private ALU. It then compares its answer with the processor's.

Any disagreement sets a sticky error flag and pulses an interrupt request toward the processor. A store to the checker address that no announced operation expects counts as a fault as well. Examples are a stray store, or a fourth store after the result has already been taken. Only the few operations selected for protection are duplicated. Everything else the processor does passes by unobserved.

Top module: `shadow_chk`

## Requirements
- R1: After reset, err_o and irq_o are low and no operation is armed.
- R2: A cycle with op_valid high arms the operation given on op_code and restarts capture at the first operand slot. A checker-address store in that same cycle is dropped, and a sequence interrupted by a new announcement is abandoned.
- R3: For two-operand operations, the first store to the checker address is source A, the second is source B and the third is the processor's result. Stores to the checker address are those with wr_en high and wr_addr equal to MATCH_ADDR.
- R4: For increment (op_code 0), the B slot is skipped, so the second store is taken as the result.
- R5: The private ALU computes, modulo 2^DATA_W, op_code 0 as A+1, op_code 1 as A+B, op_code 2 as A-B and op_code 3 as A XOR B.
- R6: When the result store disagrees with the private result, err_o is high and irq_o pulses high for exactly one cycle, both visible in the cycle after that store. When it agrees, neither rises.
- R7: A checker-address store while no operation is armed is a fault. This covers the store after a result has been captured and any store before the first announcement.
- R8: Stores to any other address, and cycles with wr_en low, change neither the outputs nor the capture position.
- R9: err_o stays high until a cycle with err_clr high and no new fault. It reads low from the following cycle. A fault in the same cycle as err_clr keeps err_o high.
- R10: Every fault pulses irq_o, including faults that occur while err_o is already high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Announces a new hardened operation |
| op_code | input | 2 | Operation being hardened (0 inc, 1 add, 2 sub, 3 xor) |
| wr_en | input | 1 | Processor data-bus write strobe |
| wr_addr | input | ADDR_W | Data-bus write address |
| wr_data | input | DATA_W | Data-bus write data |
| err_clr | input | 1 | Clears the sticky error flag |
| err_o | output | 1 | Sticky mismatch/sequence error flag |
| irq_o | output | 1 | One-cycle interrupt request per detected fault |

## Verification
The bench builds the block with an 8-bit datapath, a 16-bit address and the checker at 16'hFFF0. The narrow datapath lets hand-picked operands reach the modular edges: increment of 0xFF, an add that overflows, and a subtract that borrows. Each of these must still be treated as a match. The bench also exercises the single-operand slot skip through the fault that follows an extra store. It covers the priority of a fault over a simultaneous clear, and a store dropped on an announce cycle. With a foreign address on the bus, it shows that such a store moves neither the outputs nor the capture position.

// File: rtl/shadow_chk_pkg.sv
package shadow_chk_pkg;

    typedef enum logic [1:0] {
        HOP_INC = 2'd0,
        HOP_ADD = 2'd1,
        HOP_SUB = 2'd2,
        HOP_XOR = 2'd3
    } hop_e;

    typedef enum logic [1:0] {
        SLOT_A   = 2'd0,
        SLOT_B   = 2'd1,
        SLOT_RES = 2'd2
    } slot_e;

    function automatic logic hop_is_unary(hop_e op);
        return op == HOP_INC;
    endfunction

endpackage

// File: rtl/shadow_chk_decode.sv
module shadow_chk_decode #(
    parameter int          ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] MATCH_ADDR = '1
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              hit
);

    logic [ADDR_W-1:0] bit_eq;

    // per-bit equality against the reserved address
    for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
        assign bit_eq[i] = ~(wr_addr[i] ^ MATCH_ADDR[i]);
    end

    assign hit = wr_en & (&bit_eq);

endmodule

// File: rtl/shadow_chk_alu.sv
module shadow_chk_alu
    import shadow_chk_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  hop_e              op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);

    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    always_comb begin
        unique case (op)
            HOP_INC: y = a + ONE;
            HOP_ADD: y = a + b;
            HOP_SUB: y = a - b;
            HOP_XOR: y = a ^ b;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/shadow_chk_seq.sv
module shadow_chk_seq
    import shadow_chk_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  hop_e              op_in,
    input  logic              hit,
    input  logic [DATA_W-1:0] wr_data,
    output hop_e              op_q,
    output logic [DATA_W-1:0] opa_q,
    output logic [DATA_W-1:0] opb_q,
    output logic              res_done,
    output logic              stray
);

    typedef struct packed {
        logic              armed;
        slot_e             slot;
        hop_e              op;
        logic [DATA_W-1:0] opa;
        logic [DATA_W-1:0] opb;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        res_done = 1'b0;
        stray    = 1'b0;
        if (op_valid) begin
            // a new announcement restarts capture; a coincident store is dropped
            s_d.armed = 1'b1;
            s_d.slot  = SLOT_A;
            s_d.op    = op_in;
            s_d.opb   = '0;
        end else if (hit) begin
            if (!s_q.armed) begin
                stray = 1'b1;
            end else begin
                unique case (s_q.slot)
                    SLOT_A: begin
                        s_d.opa  = wr_data;
                        s_d.slot = hop_is_unary(s_q.op) ? SLOT_RES : SLOT_B;
                    end
                    SLOT_B: begin
                        s_d.opb  = wr_data;
                        s_d.slot = SLOT_RES;
                    end
                    default: begin
                        res_done  = 1'b1;
                        s_d.armed = 1'b0;
                        s_d.slot  = SLOT_A;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{armed: 1'b0, slot: SLOT_A, op: HOP_INC, opa: '0, opb: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign op_q  = s_q.op;
    assign opa_q = s_q.opa;
    assign opb_q = s_q.opb;

endmodule

// File: rtl/shadow_chk.sv
module shadow_chk
    import shadow_chk_pkg::*;
#(
    parameter int                DATA_W     = 32,
    parameter int                ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] MATCH_ADDR = 32'hFFFF_FFF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [1:0]        op_code,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              err_clr,
    output logic              err_o,
    output logic              irq_o
);

    typedef struct packed {
        logic err;
        logic irq;
    } flag_t;

    logic              hit;
    hop_e              cur_op;
    logic [DATA_W-1:0] opa, opb, shadow_y;
    logic              res_done, stray, fault;
    flag_t             f_d, f_q;

    shadow_chk_decode #(
        .ADDR_W     (ADDR_W),
        .MATCH_ADDR (MATCH_ADDR)
    ) u_decode (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .hit     (hit)
    );

    shadow_chk_seq #(
        .DATA_W (DATA_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_valid (op_valid),
        .op_in    (hop_e'(op_code)),
        .hit      (hit),
        .wr_data  (wr_data),
        .op_q     (cur_op),
        .opa_q    (opa),
        .opb_q    (opb),
        .res_done (res_done),
        .stray    (stray)
    );

    shadow_chk_alu #(
        .DATA_W (DATA_W)
    ) u_alu (
        .op (cur_op),
        .a  (opa),
        .b  (opb),
        .y  (shadow_y)
    );

    always_comb begin
        fault   = stray | (res_done & (wr_data != shadow_y));
        f_d.err = fault | (f_q.err & ~err_clr);
        f_d.irq = fault;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign err_o = f_q.err;
    assign irq_o = f_q.irq;

endmodule

// File: rtl/shadow_chk_sva.sv
module shadow_chk_sva #(
    parameter int                ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] MATCH_ADDR = '1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              err_clr,
    input logic              err_o,
    input logic              irq_o
);

    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_o && !err_clr |=> err_o);

    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        err_clr && !wr_en |=> !err_o);

    a_r10_irq_has_err: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> err_o);

    a_r6_rise_pulses_irq: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> irq_o);

    a_r8_foreign_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || wr_addr != MATCH_ADDR) |=> !irq_o);

    a_r2_announce_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> !irq_o);

endmodule

bind shadow_chk shadow_chk_sva #(
    .ADDR_W     (ADDR_W),
    .MATCH_ADDR (MATCH_ADDR)
) u_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .err_clr  (err_clr),
    .err_o    (err_o),
    .irq_o    (irq_o)
);

// File: tb/shadow_chk_tb.sv
`timescale 1ns/1ps
module shadow_chk_tb;

    localparam int          DW    = 8;
    localparam int          AW    = 16;
    localparam logic [15:0] CADDR = 16'hFFF0;
    localparam logic [15:0] OTHER = 16'h1234;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          op_valid = 1'b0;
    logic [1:0]    op_code = 2'd0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          err_clr = 1'b0;
    logic          err_o, irq_o;

    int total = 0;
    int fails = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    shadow_chk #(.DATA_W(DW), .ADDR_W(AW), .MATCH_ADDR(CADDR)) u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .err_clr(err_clr), .err_o(err_o), .irq_o(irq_o)
    );

    task automatic chk(input logic act, input logic exp, input string tag);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic expect_out(input logic e, input logic i, input string tag);
        chk(err_o, e, {tag, " err_o"});
        chk(irq_o, i, {tag, " irq_o"});
    endtask

    task automatic announce(input logic [1:0] op);
        op_valid = 1'b1; op_code = op;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic clear_err();
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
    endtask

    task automatic t_reset();
        expect_out(1'b0, 1'b0, "R1 reset");
        wr(CADDR, 8'h11);   // nothing armed yet
        expect_out(1'b1, 1'b1, "R7 store before announce");
        clear_err();
        expect_out(1'b0, 1'b0, "R9 clear");
    endtask

    task automatic t_add();
        announce(2'd1);
        wr(CADDR, 8'd5);
        expect_out(1'b0, 1'b0, "R3 operand A quiet");
        wr(CADDR, 8'd7);
        wr(CADDR, 8'd12);
        expect_out(1'b0, 1'b0, "R5 add match");
        announce(2'd1);
        wr(CADDR, 8'd200); wr(CADDR, 8'd100); wr(CADDR, 8'd44);
        expect_out(1'b0, 1'b0, "R5 add wrap");
        announce(2'd1);
        wr(CADDR, 8'd1); wr(CADDR, 8'd2); wr(CADDR, 8'd4);
        expect_out(1'b1, 1'b1, "R6 add mismatch");
        @(negedge clk);
        expect_out(1'b1, 1'b0, "R9 sticky, R6 single pulse");
        clear_err();
        expect_out(1'b0, 1'b0, "R9 clear");
    endtask

    task automatic t_sub_xor();
        announce(2'd2);
        wr(CADDR, 8'd3); wr(CADDR, 8'd5); wr(CADDR, 8'hFE);
        expect_out(1'b0, 1'b0, "R5 sub borrow");
        announce(2'd2);
        wr(CADDR, 8'd10); wr(CADDR, 8'd4); wr(CADDR, 8'd7);
        expect_out(1'b1, 1'b1, "R6 sub mismatch");
        clear_err();
        announce(2'd3);
        wr(CADDR, 8'hA5); wr(CADDR, 8'h0F); wr(CADDR, 8'hAA);
        expect_out(1'b0, 1'b0, "R5 xor match");
        announce(2'd3);
        wr(CADDR, 8'h01); wr(CADDR, 8'h01); wr(CADDR, 8'h01);
        expect_out(1'b1, 1'b1, "R6 xor mismatch");
        clear_err();
    endtask

    task automatic t_inc();
        announce(2'd0);
        wr(CADDR, 8'hFF); wr(CADDR, 8'h00);
        expect_out(1'b0, 1'b0, "R4 inc wrap");
        announce(2'd0);
        wr(CADDR, 8'd4); wr(CADDR, 8'd5);
        expect_out(1'b0, 1'b0, "R4 inc match");
        wr(CADDR, 8'd5);    // slot already consumed: must be stray
        expect_out(1'b1, 1'b1, "R4 second store is result, R7 extra store");
        clear_err();
        announce(2'd0);
        wr(CADDR, 8'd4); wr(CADDR, 8'd9);
        expect_out(1'b1, 1'b1, "R4 inc mismatch on second store");
        clear_err();
    endtask

    task automatic t_foreign();
        announce(2'd1);
        wr(CADDR, 8'd1);
        wr(OTHER, 8'd77);
        expect_out(1'b0, 1'b0, "R8 foreign store");
        wr_addr = CADDR; wr_data = 8'd99;   // strobe low
        @(negedge clk);
        expect_out(1'b0, 1'b0, "R8 strobe low");
        wr(CADDR, 8'd2); wr(CADDR, 8'd3);
        expect_out(1'b0, 1'b0, "R8 capture position unmoved");
    endtask

    task automatic t_announce();
        op_valid = 1'b1; op_code = 2'd1;
        wr_en = 1'b1; wr_addr = CADDR; wr_data = 8'd50;
        @(negedge clk);
        op_valid = 1'b0; wr_en = 1'b0;
        expect_out(1'b0, 1'b0, "R2 announce cycle");
        wr(CADDR, 8'd1); wr(CADDR, 8'd2); wr(CADDR, 8'd3);
        expect_out(1'b0, 1'b0, "R2 coincident store dropped");
        announce(2'd1);
        wr(CADDR, 8'd9);
        announce(2'd2);
        wr(CADDR, 8'd8); wr(CADDR, 8'd3); wr(CADDR, 8'd5);
        expect_out(1'b0, 1'b0, "R2 restart mid sequence");
    endtask

    task automatic t_race();
        announce(2'd1);
        wr(CADDR, 8'd1); wr(CADDR, 8'd1); wr(CADDR, 8'd5);
        expect_out(1'b1, 1'b1, "R6 mismatch");
        @(negedge clk);
        wr(CADDR, 8'd0);    // unarmed, flag already set
        expect_out(1'b1, 1'b1, "R10 irq while flagged");
        err_clr = 1'b1;
        wr(CADDR, 8'd0);    // fault together with clear
        err_clr = 1'b0;
        expect_out(1'b1, 1'b1, "R9 fault beats clear");
        @(negedge clk);
        expect_out(1'b1, 1'b0, "R9 still flagged");
        clear_err();
        expect_out(1'b0, 1'b0, "R9 clear");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_add();
        t_sub_xor();
        t_inc();
        t_foreign();
        t_announce();
        t_race();
        finished = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule